// File: doc/BRIEF.md
# Parallel-In Serial-Out Register with Clock Inhibit

This block is an eight-stage (by default) input-expansion register. A set of parallel data inputs is captured into the stages while an active-low load control is held low. Once load is released, each valid shift event moves the contents one stage toward the output end. The last stage drives a true serial output and an inverted copy of it. A serial input feeds the first stage on every shift, so the serial output of one register can be wired to the serial input of the next to form a longer chain.

The design runs synchronously on a fast system clock. The external shift clock pin and the inhibit pin are slow, asynchronous signals. Each passes through a two-flop synchronizer, and a shift event is detected on the synchronized values. The two pins play symmetric roles. A rising edge on the shift clock while inhibit is low is a shift. A rising edge on inhibit while the shift clock is low is also a shift. The load control is sampled directly on the system clock and is level-sensitive. While it is low it overrides every other input.

Top module: `piso_inhibit_reg`

## Requirements
- R1: While reset is asserted and after it is released, with no stimulus applied, all stages are zero, `ser_o` is 0 and `ser_no` is 1.
- R2: While `load_ni` is low at a rising `clk_i` edge, stage k takes `par_i[k]`, whatever the levels of `shift_clk_i`, `inhibit_i` and `ser_i`. After the load, `ser_o` equals `par_i[WIDTH-1]` from the following cycle on.
- R3: While `load_ni` is high, changes on `par_i` have no effect, and the register holds its contents unless a shift event occurs.
- R4: A rising edge on `shift_clk_i` while `inhibit_i` is low and `load_ni` is high causes one shift. On a shift, stage k+1 takes stage k and stage 0 takes `ser_i`. The new value is visible on `ser_o` after the third rising `clk_i` edge that follows the pin change: two synchronizer flops, then one register.
- R5: A rising edge on `inhibit_i` while `shift_clk_i` is low and `load_ni` is high also causes exactly one shift.
- R6: None of the following causes a shift: a rising edge on `shift_clk_i` while `inhibit_i` is high, a rising edge on `inhibit_i` while `shift_clk_i` is high, or a falling edge on either pin.
- R7: A shift event that occurs while `load_ni` is low is discarded. The register holds the loaded parallel data.
- R8: `ser_no` is always the inverse of `ser_o`.
- R9: After a load, successive shifts present `par_i[WIDTH-1]`, `par_i[WIDTH-2]`, ..., `par_i[0]` on `ser_o`. These are followed by the `ser_i` values in the order they were sampled, which is what makes cascading work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| par_i | input | WIDTH | Parallel data; bit WIDTH-1 leaves first |
| load_ni | input | 1 | Active-low parallel load, level-sensitive |
| ser_i | input | 1 | Serial data into stage 0 |
| shift_clk_i | input | 1 | External shift clock pin (asynchronous) |
| inhibit_i | input | 1 | External clock-inhibit pin (asynchronous) |
| ser_o | output | 1 | Last stage value |
| ser_no | output | 1 | Inverse of the last stage value |

## Verification
The bench targets the inhibit pin acting as a clock. A design that treats inhibit only as a gate would miss the shift that an inhibit rising edge produces while the shift clock is low. It would also shift wrongly on a shift clock rise while inhibit is high. The bench holds load low across a shift-clock rise: a design without load priority would shift the loaded data and show the wrong bit. It also reads out a complete chain, with parallel bits first and then serial input bits. A reversed stage order or a serial input entering the wrong end would put the bits out of order.

// File: rtl/piso_pkg.sv
package piso_pkg;

  // Per-cycle action on the stage chain, chosen by the edge controller.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } act_e;

endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Assertion is immediate, release waits STAGES edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= '0;
    end else begin
      ff_q <= ff_d;
    end
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/piso_edge_ctl.sv
module piso_edge_ctl
  import piso_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic inh_s_i,
  input  logic load_ni,
  output act_e act_o
);

  logic sclk_prev_q, sclk_prev_d;
  logic inh_prev_q,  inh_prev_d;
  logic sclk_rise, inh_rise;
  logic shift_evt;

  // Next-state for the edge history.
  always_comb begin
    sclk_prev_d = sclk_s_i;
    inh_prev_d  = inh_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      inh_prev_q  <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_prev_d;
      inh_prev_q  <= inh_prev_d;
    end
  end

  // The two pins are interchangeable: each one's rising edge counts only
  // while the other one sits low.
  always_comb begin
    sclk_rise = sclk_s_i & ~sclk_prev_q;
    inh_rise  = inh_s_i  & ~inh_prev_q;
    shift_evt = (sclk_rise & ~inh_s_i) | (inh_rise & ~sclk_s_i);
  end

  // Load is level-sensitive and wins over any coincident shift event.
  always_comb begin
    if (!load_ni) begin
      act_o = ACT_LOAD;
    end else if (shift_evt) begin
      act_o = ACT_SHIFT;
    end else begin
      act_o = ACT_HOLD;
    end
  end

  // R7
  shift_only_unloaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o == ACT_SHIFT) |-> load_ni);

  // R6
  shift_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o == ACT_SHIFT) |-> ($past(sclk_s_i) != sclk_s_i) || ($past(inh_s_i) != inh_s_i));

endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_e             act_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stage_o
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;
  logic             stage_en;

  always_comb begin
    stage_en = (act_i != ACT_HOLD);
  end

  // Per-stage next value: parallel input on load, upstream neighbour on shift.
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic upstream;
    if (k == 0) begin : g_head
      assign upstream = ser_i;
    end else begin : g_body
      assign upstream = stage_q[k-1];
    end

    always_comb begin
      stage_d[k] = (act_i == ACT_LOAD) ? par_i[k] : upstream;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  assign stage_o = stage_q;

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_HOLD) |=> $stable(stage_q));

  // R4
  shift_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_SHIFT) |=> (stage_q[LAST:1] == $past(stage_q[LAST-1:0]))
                             && (stage_q[0] == $past(ser_i)));

endmodule

// File: rtl/piso_inhibit_reg.sv
module piso_inhibit_reg
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] par_i,
  input  logic             load_ni,
  input  logic             ser_i,
  input  logic             shift_clk_i,
  input  logic             inhibit_i,
  output logic             ser_o,
  output logic             ser_no
);

  localparam int LAST     = WIDTH - 1;
  localparam int NUM_PINS = 2;
  localparam int PIN_SCLK = 0;
  localparam int PIN_INH  = 1;

  logic                rst_sync_n;
  logic [NUM_PINS-1:0] pin_raw;
  logic [NUM_PINS-1:0] pin_sync;
  act_e                act;
  logic [WIDTH-1:0]    stage;

  piso_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  assign pin_raw[PIN_SCLK] = shift_clk_i;
  assign pin_raw[PIN_INH]  = inhibit_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_sync
    piso_sync #(
      .STAGES(SYNC_STAGES)
    ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .d_i   (pin_raw[p]),
      .q_o   (pin_sync[p])
    );
  end

  piso_edge_ctl u_edge_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .sclk_s_i(pin_sync[PIN_SCLK]),
    .inh_s_i (pin_sync[PIN_INH]),
    .load_ni (load_ni),
    .act_o   (act)
  );

  piso_stage_chain #(
    .WIDTH(WIDTH)
  ) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .act_i  (act),
    .par_i  (par_i),
    .ser_i  (ser_i),
    .stage_o(stage)
  );

  assign ser_o  = stage[LAST];
  assign ser_no = ~stage[LAST];

  // R2
  load_to_output_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !load_ni |=> (ser_o == $past(par_i[LAST])));

endmodule

// File: tb/tb_piso_inhibit_reg.sv
module tb_piso_inhibit_reg;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] par;
  logic         load_n;
  logic         ser;
  logic         sclk;
  logic         inh;
  logic         ser_o;
  logic         ser_no;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_q;

  piso_inhibit_reg #(.WIDTH(W)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .par_i      (par),
    .load_ni    (load_n),
    .ser_i      (ser),
    .shift_clk_i(sclk),
    .inhibit_i  (inh),
    .ser_o      (ser_o),
    .ser_no     (ser_no)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Model from the requirements: shift toward the last stage, ser enters stage 0.
  function automatic logic [W-1:0] shifted(logic [W-1:0] v, logic s);
    return {v[W-2:0], s};
  endfunction

  task automatic check(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, expv);
    end
  endtask

  task automatic check_out(string req);
    check(req, ser_o, exp_q[W-1]);
    check("R8", ser_no, ~exp_q[W-1]);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Change one pin, wait past sync + register latency, apply model.
  task automatic set_sclk(logic v, logic shifts, string req);
    sclk = v;
    settle();
    if (shifts) exp_q = shifted(exp_q, ser);
    check_out(req);
  endtask

  task automatic set_inh(logic v, logic shifts, string req);
    inh = v;
    settle();
    if (shifts) exp_q = shifted(exp_q, ser);
    check_out(req);
  endtask

  task automatic do_load(logic [W-1:0] v);
    par = v;
    load_n = 1'b0;
    settle();
    exp_q = v;
    check_out("R2");
    load_n = 1'b1;
    settle();
    check_out("R2");
  endtask

  initial begin
    logic [W-1:0] pat;
    logic [W-1:0] sbits;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; par = '0; load_n = 1'b1; ser = 1'b0; sclk = 1'b0; inh = 1'b0;
    exp_q = '0;
    repeat (3) @(negedge clk);
    check_out("R1");
    rst_n = 1'b1;
    settle();
    check_out("R1");

    // R2: load regardless of other pins, with ser high and inhibit high
    ser = 1'b1; inh = 1'b1;
    do_load(8'hA5);
    set_inh(1'b0, 1'b0, "R6");
    ser = 1'b0;

    // R3: parallel changes ignored while load high
    par = 8'h3C; settle(); check_out("R3");
    par = 8'hFF; settle(); check_out("R3");

    // R9: full read-out, parallel bits then serial bits
    do_load(8'h96);
    sbits = 8'b1011_0010;
    for (int i = 0; i < W; i++) begin
      check("R9", ser_o, pat_bit(8'h96, W-1-i));
      ser = sbits[i];
      set_sclk(1'b1, 1'b1, "R4");
      set_sclk(1'b0, 1'b0, "R6");
    end
    for (int i = 0; i < W; i++) begin
      check("R9", ser_o, sbits[i]);
      ser = 1'b0;
      set_sclk(1'b1, 1'b1, "R4");
      set_sclk(1'b0, 1'b0, "R6");
    end

    // R5: inhibit rising while shift clock low shifts
    do_load(8'h80);
    ser = 1'b0;
    set_inh(1'b1, 1'b1, "R5");
    check("R5", ser_o, 1'b0);
    set_inh(1'b0, 1'b0, "R6");

    // R6: clock rise with inhibit high, inhibit rise with clock high
    do_load(8'h55);
    set_inh(1'b1, 1'b1, "R5");
    set_sclk(1'b1, 1'b0, "R6");
    set_sclk(1'b0, 1'b0, "R6");
    set_sclk(1'b1, 1'b0, "R6");
    set_inh(1'b0, 1'b0, "R6");
    set_inh(1'b1, 1'b0, "R6");
    set_sclk(1'b0, 1'b0, "R6");
    set_inh(1'b0, 1'b0, "R6");

    // R7: shift event while load held low is discarded
    par = 8'h7E; load_n = 1'b0; sclk = 1'b1;
    settle();
    exp_q = 8'h7E;
    check_out("R7");
    load_n = 1'b1; settle(); check_out("R7");
    set_sclk(1'b0, 1'b0, "R7");
    set_sclk(1'b1, 1'b1, "R7");
    check("R7", ser_o, 1'b1);
    set_sclk(1'b0, 1'b0, "R6");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom_range(0, 5);
      ser = 1'($urandom_range(0, 1));
      case (op)
        0: begin
          pat = W'($urandom);
          do_load(pat);
        end
        1: begin
          if (!inh) begin
            set_sclk(~sclk, !sclk, "R4");
          end else begin
            set_sclk(~sclk, 1'b0, "R6");
          end
        end
        2: begin
          if (!sclk) begin
            set_inh(~inh, !inh, "R5");
          end else begin
            set_inh(~inh, 1'b0, "R6");
          end
        end
        default: begin
          par = W'($urandom);
          settle();
          check_out("R3");
        end
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic pat_bit(logic [W-1:0] v, int idx);
    return v[idx];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule